// File: doc/BRIEF.md
# Shortest path coprocessor host interface

This block is the top of a slave coprocessor that finds single-source shortest paths on a graph held in an array of node processing elements (PEs), one PE per graph node. A host drives a 2-bit instruction code every cycle and shares a single data bus with the PEs. On chip the bidirectional bus is modelled as a host input word, per-PE data words with per-PE drive enables, and an owner-select multiplexer that produces the resolved bus value, which is returned to the host.

The host loads the graph one link at a time. Each link takes two bus beats: the start index and weight first, then the end index. Each complete link is broadcast to every PE in parallel. The host then names a source node and starts the solve, and after that it only watches the bus. The solve is finished when the source node's PE places the all-ones word on the bus. The host then fetches per-node results one node at a time, in node order, and each fetch tells the addressed PE to drive its cost and predecessor. A separator code must stand between any two host instructions. The same code also hands the bus to the PE array.

Top module: `spath_host_if`

## Requirements
- R1: While reset is asserted, `link_vld_o`, `solve_go_o` and `fetch_go_o` are 0 and the fetch pointer is cleared. A separator must be sampled after reset before any instruction takes effect.
- R2: Codes are 00 = link beat, 01 = solve, 10 = fetch and 11 = separator. A 00, 01 or 10 code takes effect only if the code sampled on the previous edge was 11. A code held for several cycles acts once.
- R3: A link is two consecutive 00 beats. In the first beat, bits [IDX_W-1:0] hold the start index and bits [BUS_W-1:IDX_W] hold the weight. In the second beat, bits [IDX_W-1:0] hold the end index. In the cycle after the second beat's edge, `link_vld_o` is 1 for exactly one cycle and the three link fields appear on the link outputs.
- R4: If any code other than 00 follows a first link beat, that link is dropped and no `link_vld_o` pulse occurs. A later complete link is still accepted normally.
- R5: An accepted 01 code takes the source index from bits [IDX_W-1:0] of the host word and pulses `solve_go_o` for one cycle with `solve_src_o` set. The block is then busy.
- R6: When the code is 00 or 01, the host owns the bus and `bus_o` equals `host_data_i`. When the code is 10 or 11, `bus_o` equals the word of the one PE whose drive enable is set, or zero if no PE drives. At most one PE drive enable may be set at a time.
- R7: While busy and the PE array owns the bus, an all-ones `bus_o` ends the busy state.
- R8: While busy, 00, 01 and 10 codes are ignored. No link, solve or fetch pulse results.
- R9: An accepted 10 code pulses `fetch_go_o` for one cycle with `fetch_idx_o` equal to the fetch pointer. The pointer then steps up by one and wraps from NODE_CNT-1 to 0. An accepted 01 code returns the pointer to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| code_i | input | 2 | Host instruction code |
| host_data_i | input | BUS_W | Word the host drives on the bus |
| pe_drv_i | input | NODE_CNT | Per-PE bus drive enables |
| pe_data_i | input | NODE_CNT*BUS_W | Per-PE bus words, PE k in slice k |
| bus_o | output | BUS_W | Resolved shared bus value |
| link_vld_o | output | 1 | Link broadcast strobe |
| link_src_o | output | IDX_W | Link start node index |
| link_dst_o | output | IDX_W | Link end node index |
| link_wt_o | output | WEIGHT_W | Link weight |
| solve_go_o | output | 1 | Start-solve strobe to all PEs |
| solve_src_o | output | IDX_W | Source node of the solve |
| fetch_go_o | output | 1 | Result fetch strobe |
| fetch_idx_o | output | IDX_W | Node whose result is fetched |

## Verification
Assertions check several rules on every cycle. At most one PE may drive the bus. Every strobe must follow a sampled separator or, for a link, a first beat. No fetch may issue while a solve is running, and the fetch pointer must stay in range. The directed scenarios are the only evidence for the other behaviours: the exact packing of link fields, dropping a half-sent link, ending busy on the all-ones word, the order in which the fetch pointer wraps and is reset, and ignoring host instructions while a solve is in progress.

// File: rtl/spath_pkg.sv
package spath_pkg;

   typedef enum logic [1:0] {
      OP_LINK  = 2'b00,
      OP_SOLVE = 2'b01,
      OP_FETCH = 2'b10,
      OP_SEP   = 2'b11
   } op_e;

   function automatic logic host_owns(input logic [1:0] code);
      return (code == OP_LINK) || (code == OP_SOLVE);
   endfunction

endpackage

// File: rtl/spath_bus_mux.sv
module spath_bus_mux
   import spath_pkg::*;
#(
   parameter int NODE_CNT = 16,
   parameter int BUS_W    = 12
) (
   input  logic                      clk_i,
   input  logic                      rst_ni,
   input  logic [1:0]                code_i,
   input  logic [BUS_W-1:0]          host_data_i,
   input  logic [NODE_CNT-1:0]       pe_drv_i,
   input  logic [NODE_CNT*BUS_W-1:0] pe_data_i,
   output logic [BUS_W-1:0]          bus_o
);

   logic [BUS_W-1:0] gated [NODE_CNT];
   logic [BUS_W-1:0] pe_or;

   for (genvar k = 0; k < NODE_CNT; k++) begin : g_gate
      assign gated[k] = pe_drv_i[k] ? pe_data_i[k*BUS_W +: BUS_W] : '0;
   end

   always_comb begin
      pe_or = '0;
      for (int k = 0; k < NODE_CNT; k++) begin
         pe_or = pe_or | gated[k];
      end
   end

   assign bus_o = host_owns(code_i) ? host_data_i : pe_or;

   AST_ONE_DRIVER: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(pe_drv_i)); // R6

endmodule

// File: rtl/spath_link_asm.sv
module spath_link_asm
   import spath_pkg::*;
#(
   parameter int IDX_W    = 4,
   parameter int WEIGHT_W = 8,
   parameter int BUS_W    = 12
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic [1:0]          code_i,
   input  logic                accept_i,
   input  logic [BUS_W-1:0]    word_i,
   input  logic [IDX_W-1:0]    dst_i,
   output logic                link_vld_o,
   output logic [IDX_W-1:0]    link_src_o,
   output logic [IDX_W-1:0]    link_dst_o,
   output logic [WEIGHT_W-1:0] link_wt_o
);

   logic                second_q;
   logic [IDX_W-1:0]    src_q;
   logic [WEIGHT_W-1:0] wt_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         second_q   <= 1'b0;
         src_q      <= '0;
         wt_q       <= '0;
         link_vld_o <= 1'b0;
         link_src_o <= '0;
         link_dst_o <= '0;
         link_wt_o  <= '0;
      end else begin
         link_vld_o <= 1'b0;
         if (second_q) begin
            second_q <= 1'b0;
            if (code_i == OP_LINK) begin
               link_vld_o <= 1'b1;
               link_src_o <= src_q;
               link_wt_o  <= wt_q;
               link_dst_o <= dst_i;
            end
         end else if (accept_i && code_i == OP_LINK) begin
            second_q <= 1'b1;
            src_q    <= word_i[IDX_W-1:0];
            wt_q     <= word_i[BUS_W-1:IDX_W];
         end
      end
   end

   AST_LINK_TWO_BEATS: assert property (@(posedge clk_i) disable iff (!rst_ni) link_vld_o |-> $past(code_i) == OP_LINK); // R3
   AST_LINK_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni) link_vld_o |=> !link_vld_o); // R3

endmodule

// File: rtl/spath_seq.sv
module spath_seq
   import spath_pkg::*;
#(
   parameter int NODE_CNT = 16,
   parameter int IDX_W    = 4,
   parameter int BUS_W    = 12
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [1:0]       code_i,
   input  logic [BUS_W-1:0] bus_i,
   output logic             accept_o,
   output logic             solve_go_o,
   output logic [IDX_W-1:0] solve_src_o,
   output logic             fetch_go_o,
   output logic [IDX_W-1:0] fetch_idx_o
);

   localparam logic [BUS_W-1:0] DONE_WORD = '1;
   localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(NODE_CNT - 1);

   logic             armed_q;
   logic             busy_q;
   logic [IDX_W-1:0] ptr_q;
   logic             done_seen;

   assign accept_o  = armed_q && !busy_q;
   assign done_seen = busy_q && !host_owns(code_i) && (bus_i == DONE_WORD);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         armed_q     <= 1'b0;
         busy_q      <= 1'b0;
         ptr_q       <= '0;
         solve_go_o  <= 1'b0;
         solve_src_o <= '0;
         fetch_go_o  <= 1'b0;
         fetch_idx_o <= '0;
      end else begin
         armed_q    <= (code_i == OP_SEP);
         solve_go_o <= 1'b0;
         fetch_go_o <= 1'b0;
         if (accept_o && code_i == OP_SOLVE) begin
            solve_go_o  <= 1'b1;
            solve_src_o <= bus_i[IDX_W-1:0];
            busy_q      <= 1'b1;
            ptr_q       <= '0;
         end else if (done_seen) begin
            busy_q <= 1'b0;
         end
         if (accept_o && code_i == OP_FETCH) begin
            fetch_go_o  <= 1'b1;
            fetch_idx_o <= ptr_q;
            ptr_q       <= (ptr_q == LAST_IDX) ? '0 : ptr_q + 1'b1;
         end
      end
   end

   AST_SOLVE_AFTER_SEP: assert property (@(posedge clk_i) disable iff (!rst_ni) solve_go_o |-> $past(armed_q)); // R2
   AST_SOLVE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni) solve_go_o |=> !solve_go_o); // R5
   AST_FETCH_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni) fetch_go_o |-> !$past(busy_q)); // R8
   AST_PTR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni) ptr_q <= LAST_IDX); // R9

endmodule

// File: rtl/spath_host_if.sv
module spath_host_if
   import spath_pkg::*;
#(
   parameter int NODE_CNT = 16,
   parameter int WEIGHT_W = 8,
   localparam int IDX_W   = (NODE_CNT > 1) ? $clog2(NODE_CNT) : 1,
   localparam int BUS_W   = IDX_W + WEIGHT_W
) (
   input  logic                      clk_i,
   input  logic                      rst_ni,
   input  logic [1:0]                code_i,
   input  logic [BUS_W-1:0]          host_data_i,
   input  logic [NODE_CNT-1:0]       pe_drv_i,
   input  logic [NODE_CNT*BUS_W-1:0] pe_data_i,
   output logic [BUS_W-1:0]          bus_o,
   output logic                      link_vld_o,
   output logic [IDX_W-1:0]          link_src_o,
   output logic [IDX_W-1:0]          link_dst_o,
   output logic [WEIGHT_W-1:0]       link_wt_o,
   output logic                      solve_go_o,
   output logic [IDX_W-1:0]          solve_src_o,
   output logic                      fetch_go_o,
   output logic [IDX_W-1:0]          fetch_idx_o
);

   if (NODE_CNT < 2) begin : g_bad_nodes
      $error("NODE_CNT must be at least 2");
   end
   if (WEIGHT_W < 2) begin : g_bad_weight
      $error("WEIGHT_W must be at least 2");
   end

   logic accept;

   spath_bus_mux #(.NODE_CNT(NODE_CNT), .BUS_W(BUS_W)) u_mux (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .code_i      (code_i),
      .host_data_i (host_data_i),
      .pe_drv_i    (pe_drv_i),
      .pe_data_i   (pe_data_i),
      .bus_o       (bus_o)
   );

   spath_seq #(.NODE_CNT(NODE_CNT), .IDX_W(IDX_W), .BUS_W(BUS_W)) u_seq (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .code_i      (code_i),
      .bus_i       (bus_o),
      .accept_o    (accept),
      .solve_go_o  (solve_go_o),
      .solve_src_o (solve_src_o),
      .fetch_go_o  (fetch_go_o),
      .fetch_idx_o (fetch_idx_o)
   );

   spath_link_asm #(.IDX_W(IDX_W), .WEIGHT_W(WEIGHT_W), .BUS_W(BUS_W)) u_link (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .code_i     (code_i),
      .accept_i   (accept),
      .word_i     (bus_o),
      .dst_i      (bus_o[IDX_W-1:0]),
      .link_vld_o (link_vld_o),
      .link_src_o (link_src_o),
      .link_dst_o (link_dst_o),
      .link_wt_o  (link_wt_o)
   );

endmodule

// File: tb/spath_host_if_bench.sv
module spath_host_if_bench;

   localparam int CLK_PERIOD = 10;
   localparam int N  = 16;
   localparam int WW = 8;
   localparam int IW = 4;
   localparam int BW = IW + WW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    code = 2'b11;
   logic [BW-1:0] hdata = '0;
   logic [N-1:0]  pe_drv = '0;
   logic [N*BW-1:0] pe_data = '0;
   logic [BW-1:0] bus;
   logic          link_vld, solve_go, fetch_go;
   logic [IW-1:0] link_src, link_dst, solve_src, fetch_idx;
   logic [WW-1:0] link_wt;

   int checks = 0;
   int errors = 0;
   int exp_ptr = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   spath_host_if u_spath_host_if (
      .clk_i(clk), .rst_ni(rst_n), .code_i(code), .host_data_i(hdata),
      .pe_drv_i(pe_drv), .pe_data_i(pe_data), .bus_o(bus),
      .link_vld_o(link_vld), .link_src_o(link_src), .link_dst_o(link_dst),
      .link_wt_o(link_wt), .solve_go_o(solve_go), .solve_src_o(solve_src),
      .fetch_go_o(fetch_go), .fetch_idx_o(fetch_idx)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic drive(input logic [1:0] c, input logic [BW-1:0] d);
      code = c;
      hdata = d;
      #1;
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic pe_put(input int idx, input logic [BW-1:0] val);
      pe_drv = '0;
      pe_data = '0;
      pe_drv[idx] = 1'b1;
      pe_data[idx*BW +: BW] = val;
      #1;
   endtask

   task automatic pe_none();
      pe_drv = '0;
      pe_data = '0;
   endtask

   task automatic t_reset();
      code = 2'b10;
      repeat (3) tick();
      chk("R1 link_vld in reset", link_vld, 0);
      chk("R1 solve_go in reset", solve_go, 0);
      chk("R1 fetch_go in reset", fetch_go, 0);
      rst_n = 1'b1;
      tick();
      chk("R1 R2 fetch without separator after reset", fetch_go, 0);
   endtask

   task automatic t_link();
      drive(2'b11, '0); tick();
      drive(2'b00, {8'hA5, 4'd3}); tick();
      chk("R3 no strobe after first beat", link_vld, 0);
      drive(2'b00, {8'h00, 4'd7}); tick();
      chk("R3 strobe after second beat", link_vld, 1);
      chk("R3 link start", link_src, 3);
      chk("R3 link end", link_dst, 7);
      chk("R3 link weight", link_wt, 8'hA5);
      drive(2'b11, '0); tick();
      chk("R3 strobe one cycle", link_vld, 0);
   endtask

   task automatic t_abort();
      drive(2'b00, {8'h3C, 4'd9}); tick();
      drive(2'b11, '0); tick();
      drive(2'b00, {8'h11, 4'd2}); tick();
      chk("R4 dropped link gives no strobe", link_vld, 0);
      drive(2'b00, {8'hFF, 4'd6}); tick();
      chk("R4 next link accepted", link_vld, 1);
      chk("R4 next link start", link_src, 2);
      chk("R4 next link weight", link_wt, 8'h11);
      chk("R4 next link end", link_dst, 6);
      drive(2'b11, '0); tick();
   endtask

   task automatic t_solve();
      drive(2'b01, 12'h005);
      chk("R6 host owns bus on 01", bus, 12'h005);
      tick();
      chk("R5 solve strobe", solve_go, 1);
      chk("R5 solve source", solve_src, 5);
      drive(2'b11, 12'h0AA);
      chk("R6 idle array bus is zero", bus, 0);
      tick();
      chk("R5 solve strobe one cycle", solve_go, 0);
      drive(2'b10, '0); tick();
      chk("R8 fetch ignored while busy", fetch_go, 0);
      drive(2'b11, '0); tick();
      drive(2'b01, 12'h007); tick();
      chk("R8 solve ignored while busy", solve_go, 0);
      drive(2'b11, '0); tick();
      drive(2'b00, {8'h22, 4'd1}); tick();
      drive(2'b00, {8'h00, 4'd4}); tick();
      chk("R8 link ignored while busy", link_vld, 0);
      drive(2'b11, '0);
      pe_put(5, 12'h2B7);
      chk("R6 driving PE word on bus", bus, 12'h2B7);
      tick();
      pe_put(5, 12'hFFF);
      tick();
      pe_none();
      tick();
      drive(2'b10, '0); tick();
      chk("R7 busy ended by all-ones word", fetch_go, 1);
      chk("R9 pointer cleared by solve", fetch_idx, 0);
      exp_ptr = 1;
   endtask

   task automatic t_held();
      drive(2'b11, '0); tick();
      drive(2'b10, '0); tick();
      chk("R9 fetch strobe", fetch_go, 1);
      chk("R9 fetch index", fetch_idx, exp_ptr);
      exp_ptr = (exp_ptr + 1) % N;
      tick();
      chk("R2 held code acts once", fetch_go, 0);
   endtask

   task automatic t_wrap();
      for (int i = 0; i < N; i++) begin
         drive(2'b11, '0); tick();
         drive(2'b10, '0); tick();
         chk("R9 sequential fetch index", fetch_idx, exp_ptr);
         exp_ptr = (exp_ptr + 1) % N;
      end
      drive(2'b11, '0); tick();
      drive(2'b01, 12'h002); tick();
      chk("R5 second solve source", solve_src, 2);
      drive(2'b11, '0);
      pe_put(2, 12'hFFF);
      tick();
      pe_none();
      tick();
      drive(2'b10, '0); tick();
      chk("R9 pointer back to zero after new solve", fetch_idx, 0);
      drive(2'b11, '0); tick();
   endtask

   initial begin
      t_reset();
      t_link();
      t_abort();
      t_solve();
      t_held();
      t_wrap();
      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual=running expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule